// File: doc/BRIEF.md
# Watchdog and Manual Reset Supervisor

This block produces the reset that a processor sees. It drives an active-low reset and a separate active-high copy of the same reset. Three conditions can request a reset. The first is a power-good input that is low. The second is a manual-reset request that is held low. The third is a watchdog that expires because software stopped toggling its kick input. Each request is stretched: reset stays asserted for a fixed pulse after the last request goes away. Time is measured in ticks from a clock prescaler. The tick count for the watchdog timeout and the tick count for the reset pulse are both parameters, so simulation can use short values.

The watchdog counter is forced to zero for the whole time reset is asserted. It starts counting from zero when reset is released. It is also cleared by every rising or falling transition on the kick input, which is sampled on every clock with no multi-cycle filter.

A static disable flag replaces the sensing of a floating kick pin. When the flag is set, the kick input is ignored. An internal source then drives the kick path low for seven eighths of the timeout and high for the last eighth. Its transitions keep clearing the timer, so the watchdog never fires.

The power-good input also acts as the asynchronous reset of every flop in the block.

Top module: `wd_supervisor`

## Requirements
- R1: `reset_o` is the logical inverse of `resetn_o` at every sample.
- R2: When `pwr_ok` goes low, reset asserts at once, without waiting for a clock edge. After `pwr_ok` rises, it passes through a synchroniser of SYNC_STAGES flops. Reset is then held for RST_TICKS more ticks. With TICK_DIV=1 and `pwr_ok` raised just before clock edge E, `resetn_o` reads low at the SYNC_STAGES+RST_TICKS-1 samples taken after E, then reads high.
- R3: `mr_n` is active low. Once a low level has crossed the SYNC_STAGES-flop synchroniser, reset is asserted. Reset stays asserted for as long as `mr_n` stays low. With TICK_DIV=1, if `mr_n` falls just before edge A, `resetn_o` first reads low after edge A+SYNC_STAGES.
- R4: After `mr_n` returns high, reset is held for RST_TICKS ticks past the synchronised release. This gives SYNC_STAGES+RST_TICKS-1 low samples after the releasing edge. A low sample during that stretch restarts the count, even a single-cycle bounce.
- R5: Suppose the kick input does not change and TICK_DIV=1. After each reset release, `resetn_o` reads high at exactly WD_TICKS+1 samples. The watchdog reset that follows reads low at exactly RST_TICKS samples.
- R6: Both a rising and a falling transition of `wdi` clear the watchdog timer. With TICK_DIV=1, transitions spaced WD_TICKS cycles apart or closer never cause a reset. An edge that lands on the expiring tick wins over the expiry. Transitions spaced further apart give WD_TICKS+2 high samples, counted from release, before reset.
- R7: While reset is asserted, the watchdog timer is held at zero. It starts from zero at release however long the reset lasted, so R5's high interval holds after any reset cause.
- R8: When `wd_off` is 1, `wdi` has no effect. The internal source is low for WD_TICKS*7/8 ticks and high for the rest of each WD_TICKS period. No watchdog reset occurs.
- R9: When reset causes overlap, release is timed from the cause that clears last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Supervisor clock |
| pwr_ok | input | 1 | Power-good qualifier; low clears the block asynchronously and requests reset |
| wdi | input | 1 | Watchdog kick input; any transition clears the timer |
| mr_n | input | 1 | Manual reset request, active low |
| wd_off | input | 1 | 1 selects the internal kick source and ignores `wdi` |
| resetn_o | output | 1 | Reset to the processor, active low |
| reset_o | output | 1 | Reset to the processor, active high |

## Verification
A kick edge and a timer expiry can fall in the same clock cycle. The bench provokes this by sweeping the kick period from one cycle up to a few cycles beyond the timeout, always starting from an aligned reset release. At a period equal to the timeout, every edge lands on the expiring tick. That run must stay free of reset. One cycle longer must produce reset after exactly WD_TICKS+2 high samples. A second coincidence is a manual-reset bounce inside a running stretch, which is judged by the low-sample count after the final release.

// File: rtl/sup_pkg.sv
package sup_pkg;

   // One bit per source that can hold the processor in reset.
   typedef struct packed {
      logic pwr;
      logic man;
      logic wdog;
   } cause_t;

   // Fraction of the timeout, in eighths, that the self kick stays low.
   localparam int SELF_LOW_EIGHTHS = 7;

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_pass
         logic unused_pins;
         assign unused_pins = clk ^ arst_n;
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
               sr <= {STAGES{RST_VAL}};
            end else begin
               sr[0] <= d;
               for (int i = 1; i < STAGES; i++) sr[i] <= sr[i-1];
            end
         end
         assign q = sr[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sup_tick.sv
module sup_tick #(
   parameter int DIV = 1000
) (
   input  logic clk,
   input  logic arst_n,
   output logic tick
);

   generate
      if (DIV == 1) begin : g_every
         logic unused_pins;
         assign unused_pins = clk ^ arst_n;
         assign tick = 1'b1;
      end else begin : g_div
         localparam int PW = $clog2(DIV);
         logic [PW-1:0] pre;
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n)                 pre <= '0;
            else if (pre == PW'(DIV-1))  pre <= '0;
            else                         pre <= pre + 1'b1;
         end
         assign tick = (pre == PW'(DIV-1));
      end
   endgenerate

endmodule

// File: rtl/sup_wd_src.sv
module sup_wd_src import sup_pkg::*; #(
   parameter int PERIOD = 16
) (
   input  logic clk,
   input  logic arst_n,
   input  logic tick,
   output logic level
);

   localparam int CW       = $clog2(PERIOD + 1);
   localparam int LOW_TCKS = (PERIOD * SELF_LOW_EIGHTHS) / 8;

   logic [CW-1:0] phase;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         phase <= '0;
      end else if (tick) begin
         if (phase == CW'(PERIOD-1)) phase <= '0;
         else                        phase <= phase + 1'b1;
      end
   end

   // Low for the first seven eighths of the period, high for the rest.
   assign level = (phase >= CW'(LOW_TCKS));

endmodule

// File: rtl/sup_wd_timer.sv
module sup_wd_timer #(
   parameter int TICKS = 16,
   parameter int SYNC  = 2,
   parameter int CW    = $clog2(TICKS + 1)
) (
   input  logic          clk,
   input  logic          arst_n,
   input  logic          tick,
   input  logic          hold,
   input  logic          kick_in,
   output logic          edge_o,
   output logic [CW-1:0] cnt_o,
   output logic          expire_o
);

   logic kick_s, kick_q;

   sup_sync #(.STAGES(SYNC), .RST_VAL(1'b0)) u_kick_sync (
      .clk    (clk),
      .arst_n (arst_n),
      .d      (kick_in),
      .q      (kick_s)
   );

   // Single-cycle history: both polarities of transition count as a kick.
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) kick_q <= 1'b0;
      else         kick_q <= kick_s;
   end
   assign edge_o = kick_s ^ kick_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         cnt_o    <= '0;
         expire_o <= 1'b0;
      end else begin
         expire_o <= 1'b0;
         if (hold || edge_o) begin
            cnt_o <= '0;
         end else if (tick) begin
            if (cnt_o == CW'(TICKS-1)) begin
               cnt_o    <= '0;
               expire_o <= 1'b1;
            end else begin
               cnt_o <= cnt_o + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/sup_stretch.sv
module sup_stretch import sup_pkg::*; #(
   parameter int TICKS = 140
) (
   input  logic   clk,
   input  logic   arst_n,
   input  logic   tick,
   input  cause_t cause,
   output logic   active_o,
   output logic   resetn_o,
   output logic   reset_o
);

   localparam int CW = $clog2(TICKS + 1);

   logic [CW-1:0] width_cnt;
   logic          any_cause;

   assign any_cause = |cause;

   // The active-high and active-low pins are driven from their own flops.
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         width_cnt <= '0;
         active_o  <= 1'b1;
         resetn_o  <= 1'b0;
         reset_o   <= 1'b1;
      end else if (any_cause) begin
         width_cnt <= '0;
         active_o  <= 1'b1;
         resetn_o  <= 1'b0;
         reset_o   <= 1'b1;
      end else if (active_o && tick) begin
         if (width_cnt == CW'(TICKS-1)) begin
            width_cnt <= '0;
            active_o  <= 1'b0;
            resetn_o  <= 1'b1;
            reset_o   <= 1'b0;
         end else begin
            width_cnt <= width_cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/wd_supervisor.sv
module wd_supervisor import sup_pkg::*; #(
   parameter int TICK_DIV    = 1000,
   parameter int WD_TICKS    = 1500,
   parameter int RST_TICKS   = 140,
   parameter int SYNC_STAGES = 2,
   parameter int WDI_SYNC    = 2
) (
   input  logic clk,
   input  logic pwr_ok,
   input  logic wdi,
   input  logic mr_n,
   input  logic wd_off,
   output logic resetn_o,
   output logic reset_o
);

   localparam int WD_CW = $clog2(WD_TICKS + 1);

   if (TICK_DIV < 1) begin : g_bad_div
      $error("TICK_DIV must be at least 1");
   end
   if (WD_TICKS < 8) begin : g_bad_wd
      $error("WD_TICKS must be at least 8 so the self kick has two edges");
   end
   if (RST_TICKS < 1) begin : g_bad_rst
      $error("RST_TICKS must be at least 1");
   end
   if (SYNC_STAGES < 0 || WDI_SYNC < 0) begin : g_bad_sync
      $error("synchroniser depths cannot be negative");
   end

   logic             tick;
   logic             pwr_q;
   logic             mr_s;
   logic             self_lvl;
   logic             kick;
   logic             wd_edge;
   logic             wd_exp;
   logic             rst_act;
   logic [WD_CW-1:0] wd_cnt;
   cause_t           cause;

   sup_tick #(.DIV(TICK_DIV)) u_tick (
      .clk    (clk),
      .arst_n (pwr_ok),
      .tick   (tick)
   );

   // Power-good release is re-timed so the stretch starts on a clean edge.
   sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pwr_sync (
      .clk    (clk),
      .arst_n (pwr_ok),
      .d      (1'b1),
      .q      (pwr_q)
   );

   sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_mr_sync (
      .clk    (clk),
      .arst_n (pwr_ok),
      .d      (mr_n),
      .q      (mr_s)
   );

   sup_wd_src #(.PERIOD(WD_TICKS)) u_self (
      .clk    (clk),
      .arst_n (pwr_ok),
      .tick   (tick),
      .level  (self_lvl)
   );

   assign kick = wd_off ? self_lvl : wdi;

   sup_wd_timer #(.TICKS(WD_TICKS), .SYNC(WDI_SYNC), .CW(WD_CW)) u_wd (
      .clk      (clk),
      .arst_n   (pwr_ok),
      .tick     (tick),
      .hold     (rst_act),
      .kick_in  (kick),
      .edge_o   (wd_edge),
      .cnt_o    (wd_cnt),
      .expire_o (wd_exp)
   );

   assign cause.pwr  = ~pwr_q;
   assign cause.man  = ~mr_s;
   assign cause.wdog = wd_exp;

   sup_stretch #(.TICKS(RST_TICKS)) u_stretch (
      .clk      (clk),
      .arst_n   (pwr_ok),
      .tick     (tick),
      .cause    (cause),
      .active_o (rst_act),
      .resetn_o (resetn_o),
      .reset_o  (reset_o)
   );

endmodule

// File: rtl/sup_chk.sv
module sup_chk (
   input logic clk,
   input logic pwr_ok,
   input logic resetn_o,
   input logic reset_o,
   input logic pwr_q,
   input logic mr_s,
   input logic wd_off,
   input logic wd_edge,
   input logic wd_exp,
   input logic wd_cnt_zero
);

   // Set while the self kick has been selected since before the last release.
   logic off_since_rel;
   always_ff @(posedge clk or negedge pwr_ok) begin
      if (!pwr_ok)        off_since_rel <= 1'b0;
      else if (!wd_off)   off_since_rel <= 1'b0;
      else if (!resetn_o) off_since_rel <= 1'b1;
   end

   // R1
   out_pair_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
      resetn_o != reset_o);

   // R2
   pwr_rel_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
      $rose(resetn_o) |-> $past(pwr_q));

   // R3
   man_hold_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
      !mr_s |=> !resetn_o);

   // R4 R9
   man_rel_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
      $rose(resetn_o) |-> ($past(mr_s) && !$past(wd_exp)));

   // R5
   wd_fire_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
      wd_exp |=> !resetn_o);

   // R6
   kick_clear_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
      wd_edge |=> wd_cnt_zero);

   // R7
   hold_zero_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
      !resetn_o |=> wd_cnt_zero);

   // R8
   off_quiet_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
      off_since_rel |-> !wd_exp);

endmodule

bind wd_supervisor sup_chk u_chk (
   .clk         (clk),
   .pwr_ok      (pwr_ok),
   .resetn_o    (resetn_o),
   .reset_o     (reset_o),
   .pwr_q       (pwr_q),
   .mr_s        (mr_s),
   .wd_off      (wd_off),
   .wd_edge     (wd_edge),
   .wd_exp      (wd_exp),
   .wd_cnt_zero (wd_cnt == '0)
);

// File: tb/wd_supervisor_tb.sv
module wd_supervisor_tb;

   localparam int CLK_PERIOD = 10;
   localparam int W = 16;
   localparam int R = 10;
   localparam int S = 2;

   logic clk = 1'b0;
   logic pwr_ok, wdi, mr_n, wd_off;
   logic resetn, reset;
   int   n_cmp, n_bad, pair_err;

   always #(CLK_PERIOD/2) clk = ~clk;

   wd_supervisor #(
      .TICK_DIV(1), .WD_TICKS(W), .RST_TICKS(R), .SYNC_STAGES(S), .WDI_SYNC(0)
   ) u_dut (
      .clk(clk), .pwr_ok(pwr_ok), .wdi(wdi), .mr_n(mr_n), .wd_off(wd_off),
      .resetn_o(resetn), .reset_o(reset)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pair_look();
      if (resetn === reset) pair_err++;
   endtask

   task automatic count_low(output int n);
      n = 0;
      while (!resetn && n < 5000) begin pair_look(); n++; @(negedge clk); end
   endtask

   task automatic count_high(output int n);
      n = 0;
      while (resetn && n < 5000) begin pair_look(); n++; @(negedge clk); end
   endtask

   task automatic kick_run(input int p, input int lim, output int highs);
      highs = 0;
      while (resetn && highs < lim) begin
         if (highs % p == 0) wdi = ~wdi;
         pair_look();
         highs++;
         @(negedge clk);
      end
   endtask

   // Starts at the first high sample after a release; ends at the next one.
   task automatic manual_case(input int hold_len);
      int n, lows;
      mr_n = 1'b0; @(negedge clk);
      count_high(n);
      chk(n == S, "R3 assertion latency", n, S);
      lows = 0;
      for (int i = 0; i < hold_len; i++) begin
         pair_look();
         if (!resetn) lows++;
         @(negedge clk);
      end
      chk(lows == hold_len, "R3 held while low", lows, hold_len);
      mr_n = 1'b1; @(negedge clk);
      count_low(n);
      chk(n == S+R-1, "R4 stretch after release", n, S+R-1);
      count_high(n);
      chk(n == W+1, "R7 timer from zero after long reset", n, W+1);
      count_low(n);
      chk(n == R, "R5 watchdog pulse width", n, R);
   endtask

   initial begin
      int n;
      n_cmp = 0; n_bad = 0; pair_err = 0;
      pwr_ok = 1'b1; wdi = 1'b0; mr_n = 1'b1; wd_off = 1'b0;
      #1 pwr_ok = 1'b0;
      repeat (3) @(negedge clk);
      chk(resetn === 1'b0 && reset === 1'b1, "R2 reset state", resetn, 0);

      pwr_ok = 1'b1; @(negedge clk);
      count_low(n);
      chk(n == S+R-1, "R2 power-up stretch", n, S+R-1);

      // Free-running watchdog with a silent kick input.
      for (int i = 0; i < 3; i++) begin
         count_high(n);
         chk(n == W+1, "R5 timeout interval", n, W+1);
         count_low(n);
         chk(n == R, "R5 watchdog pulse width", n, R);
      end

      // Kick period sweep, including the edge-on-expiry coincidence.
      for (int p = 1; p <= W+3; p++) begin
         kick_run(p, 4*W+2, n);
         if (p <= W) begin
            chk(n == 4*W+2, "R6 kicks hold off reset", n, 4*W+2);
            count_high(n);
            count_low(n);
         end else begin
            chk(n == W+2, "R6 late kicks expire", n, W+2);
            count_low(n);
            chk(n == R, "R5 pulse after late kicks", n, R);
         end
      end

      manual_case(1);
      manual_case(W/2);
      manual_case(3*W);

      // Bounce inside a running stretch restarts it.
      mr_n = 1'b0; @(negedge clk);
      count_high(n);
      repeat (4) @(negedge clk);
      mr_n = 1'b1;
      repeat (R/2) @(negedge clk);
      mr_n = 1'b0; @(negedge clk);
      mr_n = 1'b1; @(negedge clk);
      count_low(n);
      chk(n == S+R-1, "R4 bounce restarts stretch", n, S+R-1);
      count_high(n);
      count_low(n);

      // Power drop mid-run: immediate assertion.
      pwr_ok = 1'b0; #1;
      chk(resetn === 1'b0 && reset === 1'b1, "R2 asynchronous assertion", resetn, 0);
      @(negedge clk);
      pwr_ok = 1'b1; @(negedge clk);
      count_low(n);
      chk(n == S+R-1, "R2 stretch after power return", n, S+R-1);
      count_high(n);
      chk(n == W+1, "R7 timer from zero after power reset", n, W+1);
      count_low(n);

      // Overlap: power drops and returns while manual reset is held.
      mr_n = 1'b0; @(negedge clk);
      count_high(n);
      repeat (3) @(negedge clk);
      pwr_ok = 1'b0; @(negedge clk);
      pwr_ok = 1'b1;
      repeat (6) @(negedge clk);
      mr_n = 1'b1; @(negedge clk);
      count_low(n);
      chk(n == S+R-1, "R9 release timed from last cause", n, S+R-1);
      count_high(n);
      count_low(n);

      // Disabled watchdog: internal source only, kick input frozen.
      mr_n = 1'b0; @(negedge clk);
      count_high(n);
      wd_off = 1'b1;
      repeat (3) @(negedge clk);
      mr_n = 1'b1; @(negedge clk);
      count_low(n);
      chk(n == S+R-1, "R4 stretch with watchdog off", n, S+R-1);
      count_high(n);
      chk(n == 5000, "R8 no reset while disabled", n, 5000);
      mr_n = 1'b0; @(negedge clk);
      count_high(n);
      wd_off = 1'b0;
      repeat (3) @(negedge clk);
      mr_n = 1'b1; @(negedge clk);
      count_low(n);
      count_high(n);
      chk(n == W+1, "R8 watchdog resumes after enable", n, W+1);
      count_low(n);

      chk(pair_err == 0, "R1 outputs complementary", pair_err, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule